// File: doc/BRIEF.md
# Chip-Chain Serial Frame Parser

This block sits behind an 8N1 serial receiver on a daisy-chained ASIC link and turns the incoming byte stream into frames. Each byte arrives with a one-cycle valid strobe. A direction select tells the parser which kind of frame to expect. Downstream commands open with 0x55 followed by 0xAA. Upstream responses open with the reverse pair, 0xAA followed by 0x55. The link may run slowly during chip discovery and much faster while hashing, so the parser makes no assumption about byte spacing beyond a programmable idle limit.

After the sync pair the parser takes a type byte and a length byte. The length counts every byte from the type through the trailing check byte, so the parser works out where the payload ends from it. Each payload byte is presented with its position. The final byte carries a 5-bit CRC in its low bits, and the parser checks it against its own CRC over the type, length and payload bytes. A length that is out of range aborts the frame. A stall in mid-frame silently drops the partial frame.

Top module: `chain_frame_parser`

## Requirements
- R1: After reset, frameDone, crcErr, lenErr and plValid are low, and frameType and plIdx are zero.
- R2: With dirUp=0 a frame starts only on 0x55 then 0xAA. The reversed pair, and bytes that are not part of a sync pair, produce no output.
- R3: With dirUp=1 a frame starts only on 0xAA then 0x55.
- R4: While the second sync byte is awaited, a repeat of the first sync byte keeps the parser waiting, so 0x55 0x55 0xAA (dirUp=0) still opens a frame.
- R5: frameType takes the byte that follows the sync pair and holds it until the next frame's type byte.
- R6: The length byte L counts the bytes from the type through the CRC byte, so the payload is L-3 bytes. Each payload byte gives a one-cycle plValid, with plData set to the byte and plIdx counting 0, 1, 2 and so on. The pulse comes in the cycle after the byte's valid strobe.
- R7: frameDone pulses for one cycle after the last byte. crcErr pulses with it when the last byte's bits [4:0] differ from the CRC-5 computed over type, length and payload. That CRC uses polynomial x^5+x^2+1 (0x05), an initial value of 0x1F, and MSB-first bit order. Bits [7:5] of the last byte are ignored.
- R8: A length below 3 or above MAX_LEN (default 32) gives a one-cycle lenErr pulse, with no payload and no frameDone. Parsing then goes back to sync hunting. Lengths of 3 (no payload) and MAX_LEN are accepted.
- R9: Once the first sync byte has been seen, gapLimit consecutive cycles with no byte (gapLimit nonzero) drop the partial frame without any pulse. The parser then hunts for sync. gapLimit=0 turns the timeout off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte |
| dirUp | input | 1 | 0: command sync 55 AA, 1: response sync AA 55 |
| gapLimit | input | GAP_W | Idle cycles that drop a partial frame, 0 disables |
| frameType | output | 8 | Type byte of the current or last frame |
| plValid | output | 1 | Payload byte strobe |
| plData | output | 8 | Payload byte |
| plIdx | output | IDX_W | Payload byte position |
| frameDone | output | 1 | Frame completed pulse |
| crcErr | output | 1 | CRC mismatch, with frameDone |
| lenErr | output | 1 | Length out of range pulse |

## Verification
The bench sends a register-read command frame and a nine-byte response frame with a nonce, job and chip fields. Together these check that both sync orders and the payload indexing work. Streams with the wrong sync order, a doubled first sync byte and noise bytes before sync show that framing locks only on the right pair. Frames with a flipped CRC bit, or with junk in the high bits of the CRC byte, separate a real integrity failure from bits the check must ignore. Length values of 2, 3, 32 and 33, a long mid-frame stall with the timeout on, and the same stall with it off, probe each boundary of the abort paths.

// File: rtl/chain_parser_pkg.sv
package chain_parser_pkg;
  localparam int HDR_CRC_LEN = 3;
  localparam logic [7:0] SYNC_A = 8'h55;
  localparam logic [7:0] SYNC_B = 8'hAA;
  localparam logic [4:0] CRC_INIT = 5'h1F;
  localparam logic [4:0] CRC_POLY = 5'h05;

  typedef struct packed {
    logic capType;
    logic crcUpd;
    logic pushPay;
    logic finish;
    logic lenBad;
  } ctrlStrobe_t;

  function automatic logic [4:0] crc5Byte(input logic [4:0] cur, input logic [7:0] d);
    logic [4:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/chain_parser_ctrl.sv
module chain_parser_ctrl
  import chain_parser_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             dirUp,
  input  logic [GAP_W-1:0] gapLimit,
  output ctrlStrobe_t      strobe
);
  localparam int REM_W = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {ST_HUNT, ST_SYNC2, ST_TYPE, ST_LEN, ST_PAY, ST_CRC} state_t;

  state_t state;
  logic [REM_W-1:0] remain;
  logic [GAP_W-1:0] idleCnt;
  logic [GAP_W-1:0] nextIdle;
  logic [7:0] syncFirst, syncSecond;
  logic midFrame, gapHit, lenOk;

  assign syncFirst  = dirUp ? SYNC_B : SYNC_A;
  assign syncSecond = dirUp ? SYNC_A : SYNC_B;
  assign midFrame   = (state != ST_HUNT);
  assign nextIdle   = idleCnt + 1'b1;
  assign gapHit     = midFrame && !byteValid && (gapLimit != '0) && (nextIdle == gapLimit);
  assign lenOk      = (byteData >= 8'(HDR_CRC_LEN)) && (byteData <= 8'(MAX_LEN));

  always_comb begin
    strobe = '0;
    if (byteValid) begin
      unique case (state)
        ST_TYPE: strobe.capType = 1'b1;
        ST_LEN: begin
          strobe.lenBad = !lenOk;
          strobe.crcUpd = lenOk;
        end
        ST_PAY: begin
          strobe.pushPay = 1'b1;
          strobe.crcUpd  = 1'b1;
        end
        ST_CRC: strobe.finish = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      remain  <= '0;
      idleCnt <= '0;
    end else if (gapHit) begin
      state   <= ST_HUNT;
      idleCnt <= '0;
    end else if (!byteValid) begin
      if (midFrame) idleCnt <= nextIdle;
    end else begin
      idleCnt <= '0;
      unique case (state)
        ST_HUNT:  if (byteData == syncFirst) state <= ST_SYNC2;
        ST_SYNC2: begin
          if (byteData == syncSecond) state <= ST_TYPE;
          else if (byteData != syncFirst) state <= ST_HUNT;
        end
        ST_TYPE: state <= ST_LEN;
        ST_LEN: begin
          if (!lenOk) state <= ST_HUNT;
          else if (byteData == 8'(HDR_CRC_LEN)) state <= ST_CRC;
          else begin
            state  <= ST_PAY;
            remain <= REM_W'(byteData - 8'(HDR_CRC_LEN));
          end
        end
        ST_PAY: begin
          remain <= remain - 1'b1;
          if (remain == REM_W'(1)) state <= ST_CRC;
        end
        ST_CRC: state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/chain_parser_dp.sv
module chain_parser_dp
  import chain_parser_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byteData,
  input  ctrlStrobe_t      strobe,
  output logic [7:0]       frameType,
  output logic             plValid,
  output logic [7:0]       plData,
  output logic [IDX_W-1:0] plIdx,
  output logic             frameDone,
  output logic             crcErr,
  output logic             lenErr
);
  logic [4:0] crcAcc;
  logic [IDX_W-1:0] idxNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcAcc    <= CRC_INIT;
      idxNext   <= '0;
      frameType <= '0;
      plValid   <= 1'b0;
      plData    <= '0;
      plIdx     <= '0;
      frameDone <= 1'b0;
      crcErr    <= 1'b0;
      lenErr    <= 1'b0;
    end else begin
      plValid   <= strobe.pushPay;
      frameDone <= strobe.finish;
      crcErr    <= strobe.finish && (byteData[4:0] != crcAcc);
      lenErr    <= strobe.lenBad;
      if (strobe.capType) begin
        frameType <= byteData;
        crcAcc    <= crc5Byte(CRC_INIT, byteData);
        idxNext   <= '0;
      end else if (strobe.crcUpd) begin
        crcAcc <= crc5Byte(crcAcc, byteData);
      end
      if (strobe.pushPay) begin
        plData  <= byteData;
        plIdx   <= idxNext;
        idxNext <= idxNext + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chain_frame_parser.sv
module chain_frame_parser
  import chain_parser_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int GAP_W = 16,
  localparam int IDX_W = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             dirUp,
  input  logic [GAP_W-1:0] gapLimit,
  output logic [7:0]       frameType,
  output logic             plValid,
  output logic [7:0]       plData,
  output logic [IDX_W-1:0] plIdx,
  output logic             frameDone,
  output logic             crcErr,
  output logic             lenErr
);
  ctrlStrobe_t strobe;

  chain_parser_ctrl #(.MAX_LEN(MAX_LEN), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .dirUp(dirUp), .gapLimit(gapLimit), .strobe(strobe)
  );

  chain_parser_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .byteData(byteData), .strobe(strobe),
    .frameType(frameType), .plValid(plValid), .plData(plData), .plIdx(plIdx),
    .frameDone(frameDone), .crcErr(crcErr), .lenErr(lenErr)
  );
endmodule

// File: rtl/chain_frame_parser_chk.sv
module chain_frame_parser_chk #(
  parameter int MAX_LEN = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byteValid,
  input logic [7:0]       frameType,
  input logic             plValid,
  input logic [IDX_W-1:0] plIdx,
  input logic             frameDone,
  input logic             crcErr,
  input logic             lenErr
);
  p_crcerr_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crcErr |-> frameDone);

  p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({plValid, frameDone, lenErr}));

  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    plValid |-> (int'(plIdx) < MAX_LEN - 3));

  p_out_follows_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (plValid || frameDone || lenErr) |-> $past(byteValid));

  p_type_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byteValid) |-> $stable(frameType));
endmodule

bind chain_frame_parser chain_frame_parser_chk #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .frameType(frameType),
  .plValid(plValid), .plIdx(plIdx), .frameDone(frameDone), .crcErr(crcErr),
  .lenErr(lenErr)
);

// File: tb/chain_frame_parser_test.sv
`timescale 1ns/1ps
module chain_frame_parser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic dirUp = 1'b0;
  logic [15:0] gapLimit = 16'd100;
  logic [7:0] frameType;
  logic plValid;
  logic [7:0] plData;
  logic [4:0] plIdx;
  logic frameDone, crcErr, lenErr;

  chain_frame_parser uut (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .dirUp(dirUp), .gapLimit(gapLimit), .frameType(frameType), .plValid(plValid),
    .plData(plData), .plIdx(plIdx), .frameDone(frameDone), .crcErr(crcErr),
    .lenErr(lenErr)
  );

  always #2 clk = ~clk;

  int testCnt = 0;
  int failCnt = 0;
  logic [7:0] txBuf [0:63];
  int txLen;
  logic [7:0] pay [0:31];
  logic [7:0] got [0:31];
  int payCnt, doneCnt, crcCnt, lenCnt;
  logic idxOk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (plValid) begin
        if (int'(plIdx) != payCnt) idxOk = 1'b0;
        got[plIdx] = plData;
        payCnt++;
      end
      if (frameDone) doneCnt++;
      if (crcErr) crcCnt++;
      if (lenErr) lenCnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk); #1;
    payCnt = 0; doneCnt = 0; crcCnt = 0; lenCnt = 0; idxOk = 1'b1;
  endtask

  function automatic logic [4:0] refCrc(input int n);
    logic [4:0] r = 5'h1F;
    for (int k = 0; k < n * 8; k++) begin
      logic bitv = txBuf[2 + k / 8][7 - (k % 8)];
      logic top = r[4];
      r = {r[3:0], 1'b0} ^ ((top ^ bitv) ? 5'h05 : 5'h00);
    end
    return r;
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    @(negedge clk); byteValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBuf();
    for (int i = 0; i < txLen; i++) sendByte(txBuf[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic buildFrame(input logic up, input logic [7:0] typ, input int nPay,
                            input logic [7:0] lenOverride, input logic [7:0] crcXor);
    txBuf[0] = up ? 8'hAA : 8'h55;
    txBuf[1] = up ? 8'h55 : 8'hAA;
    txBuf[2] = typ;
    txBuf[3] = (lenOverride != 0) ? lenOverride : 8'(nPay + 3);
    for (int i = 0; i < nPay; i++) txBuf[4 + i] = pay[i];
    txBuf[4 + nPay] = {3'b000, refCrc(nPay + 2)} ^ crcXor;
    txLen = nPay + 5;
  endtask

  task automatic checkGood(input string tag, input int nPay, input logic [7:0] typ);
    logic match = 1'b1;
    for (int i = 0; i < nPay; i++) if (got[i] !== pay[i]) match = 1'b0;
    check(payCnt == nPay && idxOk, {tag, " payload count/index"}, payCnt, nPay);
    check(match, {tag, " payload bytes"}, match, 1);
    check(doneCnt == 1 && crcCnt == 0, {tag, " frameDone clean"}, doneCnt*16+crcCnt, 16);
    check(frameType == typ, {tag, " frameType R5"}, frameType, typ);
  endtask

  task automatic t_reset();
    check(!plValid && !frameDone && !crcErr && !lenErr, "R1 pulses low", 
          {plValid, frameDone, crcErr, lenErr}, 0);
    check(frameType == 0 && plIdx == 0, "R1 frameType/plIdx zero", frameType, 0);
  endtask

  task automatic t_command();
    clearMon(); dirUp = 1'b0;
    pay[0] = 8'h00; pay[1] = 8'h00;
    buildFrame(1'b0, 8'h41, 2, 8'h00, 8'h00);
    sendBuf();
    checkGood("R2 R6 R7 command read", 2, 8'h41);
  endtask

  task automatic t_response();
    clearMon(); dirUp = 1'b1;
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h3C + i * 17);
    buildFrame(1'b1, 8'h80, 6, 8'h00, 8'h00);
    sendBuf();
    checkGood("R3 R6 nonce response", 6, 8'h80);
    dirUp = 1'b0;
  endtask

  task automatic t_wrongOrder();
    clearMon(); dirUp = 1'b0;
    pay[0] = 8'h12;
    buildFrame(1'b1, 8'h01, 1, 8'h00, 8'h00);
    sendBuf();
    check(payCnt == 0 && doneCnt == 0 && lenCnt == 0, "R2 reversed sync ignored",
          payCnt + doneCnt + lenCnt, 0);
    check(frameType == 8'h80, "R2 frameType untouched by ignored bytes", frameType, 8'h80);
  endtask

  task automatic t_doubleSync();
    clearMon(); dirUp = 1'b0;
    sendByte(8'h13); sendByte(8'h55);
    pay[0] = 8'h9E; pay[1] = 8'h07;
    buildFrame(1'b0, 8'h02, 2, 8'h00, 8'h00);
    sendBuf();
    checkGood("R4 repeated first sync", 2, 8'h02);
  endtask

  task automatic t_badCrc();
    clearMon();
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
    buildFrame(1'b0, 8'h05, 3, 8'h00, 8'h04);
    sendBuf();
    check(doneCnt == 1 && crcCnt == 1, "R7 flipped crc bit flagged", doneCnt*16+crcCnt, 17);
    clearMon();
    buildFrame(1'b0, 8'h05, 3, 8'h00, 8'hE0);
    sendBuf();
    check(doneCnt == 1 && crcCnt == 0, "R7 high crc bits ignored", doneCnt*16+crcCnt, 16);
  endtask

  task automatic t_lengths();
    clearMon();
    buildFrame(1'b0, 8'h07, 0, 8'h02, 8'h00);
    sendBuf();
    check(lenCnt == 1 && doneCnt == 0 && payCnt == 0, "R8 length 2 rejected",
          lenCnt*256 + doneCnt*16 + payCnt, 256);
    clearMon();
    buildFrame(1'b0, 8'h07, 0, 8'd33, 8'h00);
    sendBuf();
    check(lenCnt == 1 && doneCnt == 0 && payCnt == 0, "R8 length 33 rejected",
          lenCnt*256 + doneCnt*16 + payCnt, 256);
    clearMon();
    buildFrame(1'b0, 8'h08, 0, 8'h00, 8'h00);
    sendBuf();
    check(lenCnt == 0, "R8 length 3 accepted", lenCnt, 0);
    checkGood("R8 empty payload", 0, 8'h08);
    clearMon();
    for (int i = 0; i < 29; i++) pay[i] = 8'(i * 9 + 1);
    buildFrame(1'b0, 8'h09, 29, 8'h00, 8'h00);
    sendBuf();
    check(lenCnt == 0, "R8 length 32 accepted", lenCnt, 0);
    checkGood("R8 R6 max length", 29, 8'h09);
  endtask

  task automatic t_gap();
    clearMon(); gapLimit = 16'd10;
    pay[0] = 8'h21; pay[1] = 8'h22;
    buildFrame(1'b0, 8'h0A, 2, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) sendByte(txBuf[i]);
    repeat (20) @(negedge clk);
    for (int i = 3; i < txLen; i++) sendByte(txBuf[i]);
    repeat (4) @(negedge clk);
    check(payCnt == 0 && doneCnt == 0 && lenCnt == 0, "R9 stalled frame dropped",
          payCnt + doneCnt + lenCnt, 0);
    clearMon();
    sendBuf();
    checkGood("R9 recovery after drop", 2, 8'h0A);
    clearMon(); gapLimit = 16'd0;
    for (int i = 0; i < 3; i++) sendByte(txBuf[i]);
    repeat (40) @(negedge clk);
    for (int i = 3; i < txLen; i++) sendByte(txBuf[i]);
    repeat (4) @(negedge clk);
    check(doneCnt == 1 && payCnt == 2, "R9 gapLimit zero disables timeout",
          doneCnt*16 + payCnt, 18);
    gapLimit = 16'd100;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_command();
    t_response();
    t_wrongOrder();
    t_doubleSync();
    t_badCrc();
    t_lengths();
    t_gap();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule